// File: doc/BRIEF.md
# Virtual Wire Event Interrupt Unit

This block turns groups of 32 incoming virtual wire levels into one interrupt line. Each wire bit has its own trigger type, chosen by a 3-bit code. The code is spread over three configuration planes, one register per code bit. Each bit also has an enable and a sticky status flag. A status flag is set when its enabled trigger condition is seen on the sampled input. It stays set until software writes a 1 to it. The history of every wire is sampled once per clock, so edges are found by comparing the present input with the value held from the previous clock.

A second, top-level level collects the groups. Each group provides a live summary: the OR of its status bits that are still enabled. Group 0 appears at top-level bit 8 and group 1 at bit 22. A pulse on the master reset event input sets a sticky flag at top-level bit 31. The interrupt output is the OR of the top-level bits that are enabled in the top-level enable register.

Software uses a simple synchronous write port and a combinational read port. Through them it programs the trigger planes and the enables. It reads the status words and clears them by writing back the value it read.

Top module: `vw_event_irq`

## Requirements
- R1: After reset, every register reads zero, the sampled input history is zero, and `irq` is low.
- R2: Code 001 (plane T2=0, T1=0, T0=1) sets the status bit in the clock where the input goes from 0 to 1. A fall does not set it.
- R3: Code 000 sets the status bit on a 1-to-0 change only.
- R4: Code 100 sets the status bit on either change.
- R5: Code 010 sets the status bit in every clock where the input is 1. Code 011 does the same in every clock where the input is 0.
- R6: Codes 101, 110 and 111 never set the status bit.
- R7: A status bit is set only if its enable bit is 1 in the triggering clock. Enabling a bit later does not replay an edge that was missed.
- R8: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. If a trigger and a clear land on the same bit in the same clock, the bit stays set.
- R9: Top-level bit 8 is the OR of group 0 status AND enable. Bit 22 is the same for group 1. Writes to these two bits have no effect.
- R10: A one-clock pulse on `mrst_evt` sets sticky top-level bit 31. Writing 1 to bit 31 clears it, and a pulse in the same clock as the clear wins.
- R11: `irq` is high exactly when some top-level status bit is 1 and its bit in the top-level enable register is also 1.
- R12: Register addresses are as follows. 0 is the top-level enable and 1 is the top-level status. Group g uses 2+5g to 6+5g, in the order T0, T1, T2, enable, status. Unmapped addresses read zero. The T planes, the enables and the top-level enable read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vw_in | input | 64 | Wire levels, group g at bits 32g+31..32g |
| mrst_evt | input | 1 | Master reset event pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| irq | output | 1 | Interrupt request |

## Verification
A change on `vw_in` or `mrst_evt` takes one rising edge to reach the status registers. `irq` and the top-level summaries follow those registers combinationally, and a write lands at the rising edge where `wr_en` is sampled high. The bench therefore drives every stimulus on a falling edge and samples at the next falling edge. At that point exactly one register stage has passed. Reads move `rd_addr` and sample 1 ns later, with no edge in between. For each clear/trigger collision, the write and the input change go out on the same falling edge, so they meet at the same rising edge.

// File: rtl/vw_irq_pkg.sv
package vw_irq_pkg;

  localparam int NUM_GRP = 2;
  localparam int NUM_FLD = 5;
  localparam int ADDR_TOP_EN = 0;
  localparam int ADDR_TOP_ST = 1;
  localparam int GRP_BASE = 2;
  localparam int MRST_BIT = 31;

  typedef enum logic [2:0] {
    TRIG_FALL = 3'b000,
    TRIG_RISE = 3'b001,
    TRIG_HIGH = 3'b010,
    TRIG_LOW  = 3'b011,
    TRIG_BOTH = 3'b100
  } trig_e;

  typedef enum int {
    FLD_T0 = 0,
    FLD_T1 = 1,
    FLD_T2 = 2,
    FLD_EN = 3,
    FLD_ST = 4
  } fld_e;

  function automatic int grp_addr(input int g, input int f);
    return GRP_BASE + g * NUM_FLD + f;
  endfunction

  function automatic int grp_sum_bit(input int g);
    return (g == 0) ? 8 : 22;
  endfunction

  function automatic logic trig_hit(input logic [2:0] code, input logic cur,
                                    input logic prev);
    logic h;
    case (code)
      TRIG_FALL: h = prev & ~cur;
      TRIG_RISE: h = ~prev & cur;
      TRIG_HIGH: h = cur;
      TRIG_LOW:  h = ~cur;
      TRIG_BOTH: h = prev ^ cur;
      default:   h = 1'b0;
    endcase
    return h;
  endfunction

endpackage

// File: rtl/vw_trig_detect.sv
module vw_trig_detect
  import vw_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] t0,
  input  logic [W-1:0] t1,
  input  logic [W-1:0] t2,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  output logic [W-1:0] hit
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [2:0] code;
    assign code   = {t2[i], t1[i], t0[i]};
    assign hit[i] = trig_hit(code, cur[i], prev[i]);
  end

endmodule

// File: rtl/vw_event_group.sv
module vw_event_group
  import vw_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [W-1:0]       vw_in,
  input  logic [NUM_FLD-1:0] we,
  input  logic [W-1:0]       wr_data,
  output logic [W-1:0]       t0_q,
  output logic [W-1:0]       t1_q,
  output logic [W-1:0]       t2_q,
  output logic [W-1:0]       en_q,
  output logic [W-1:0]       st_q,
  output logic [W-1:0]       hit,
  output logic               summary
);

  logic [W-1:0] hist_q;
  logic [W-1:0] set_v;
  logic [W-1:0] clr_v;
  logic [W-1:0] st_d;

  vw_trig_detect #(.W(W)) u_detect (
    .t0   (t0_q),
    .t1   (t1_q),
    .t2   (t2_q),
    .cur  (vw_in),
    .prev (hist_q),
    .hit  (hit)
  );

  assign set_v = hit & en_q;
  assign clr_v = we[FLD_ST] ? wr_data : '0;
  assign st_d  = (st_q & ~clr_v) | set_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      t0_q   <= '0;
      t1_q   <= '0;
      t2_q   <= '0;
      en_q   <= '0;
      st_q   <= '0;
    end else begin
      hist_q <= vw_in;
      st_q   <= st_d;
      if (we[FLD_T0]) t0_q <= wr_data;
      if (we[FLD_T1]) t1_q <= wr_data;
      if (we[FLD_T2]) t2_q <= wr_data;
      if (we[FLD_EN]) en_q <= wr_data;
    end
  end

  assign summary = |(st_q & en_q);

endmodule

// File: rtl/vw_top_status.sv
module vw_top_status
  import vw_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_GRP-1:0] grp_sum,
  input  logic               mrst_evt,
  input  logic               en_we,
  input  logic               st_we,
  input  logic [W-1:0]       wr_data,
  output logic [W-1:0]       top_en_q,
  output logic [W-1:0]       top_st,
  output logic               irq
);

  logic mrst_q;
  logic mrst_clr;

  assign mrst_clr = st_we & wr_data[MRST_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mrst_q   <= 1'b0;
      top_en_q <= '0;
    end else begin
      mrst_q <= (mrst_q & ~mrst_clr) | mrst_evt;
      if (en_we) top_en_q <= wr_data;
    end
  end

  always_comb begin
    top_st = '0;
    for (int g = 0; g < NUM_GRP; g++) top_st[grp_sum_bit(g)] = grp_sum[g];
    top_st[MRST_BIT] = mrst_q;
  end

  assign irq = |(top_st & top_en_q);

endmodule

// File: rtl/vw_event_irq.sv
module vw_event_irq
  import vw_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_GRP*DATA_W-1:0] vw_in,
  input  logic                      mrst_evt,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      irq
);

  localparam int ALL_W = NUM_GRP * DATA_W;

  logic [ALL_W-1:0]   t0_all, t1_all, t2_all, en_all, st_all, hit_all;
  logic [NUM_GRP-1:0] grp_sum;
  logic [DATA_W-1:0]  top_en, top_st;
  logic               top_en_we, top_st_we;
  logic [DATA_W-1:0]  grp_fld [NUM_GRP][NUM_FLD];

  assign top_en_we = wr_en && (wr_addr == ADDR_W'(ADDR_TOP_EN));
  assign top_st_we = wr_en && (wr_addr == ADDR_W'(ADDR_TOP_ST));

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [NUM_FLD-1:0] we;
    for (genvar f = 0; f < NUM_FLD; f++) begin : g_we
      assign we[f] = wr_en && (wr_addr == ADDR_W'(grp_addr(g, f)));
    end

    vw_event_group #(.W(DATA_W)) u_grp (
      .clk     (clk),
      .rst_n   (rst_n),
      .vw_in   (vw_in[g*DATA_W +: DATA_W]),
      .we      (we),
      .wr_data (wr_data),
      .t0_q    (t0_all[g*DATA_W +: DATA_W]),
      .t1_q    (t1_all[g*DATA_W +: DATA_W]),
      .t2_q    (t2_all[g*DATA_W +: DATA_W]),
      .en_q    (en_all[g*DATA_W +: DATA_W]),
      .st_q    (st_all[g*DATA_W +: DATA_W]),
      .hit     (hit_all[g*DATA_W +: DATA_W]),
      .summary (grp_sum[g])
    );

    assign grp_fld[g][FLD_T0] = t0_all[g*DATA_W +: DATA_W];
    assign grp_fld[g][FLD_T1] = t1_all[g*DATA_W +: DATA_W];
    assign grp_fld[g][FLD_T2] = t2_all[g*DATA_W +: DATA_W];
    assign grp_fld[g][FLD_EN] = en_all[g*DATA_W +: DATA_W];
    assign grp_fld[g][FLD_ST] = st_all[g*DATA_W +: DATA_W];
  end

  vw_top_status #(.W(DATA_W)) u_top (
    .clk      (clk),
    .rst_n    (rst_n),
    .grp_sum  (grp_sum),
    .mrst_evt (mrst_evt),
    .en_we    (top_en_we),
    .st_we    (top_st_we),
    .wr_data  (wr_data),
    .top_en_q (top_en),
    .top_st   (top_st),
    .irq      (irq)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(ADDR_TOP_EN)) rd_data = top_en;
    if (rd_addr == ADDR_W'(ADDR_TOP_ST)) rd_data = top_st;
    for (int g = 0; g < NUM_GRP; g++)
      for (int f = 0; f < NUM_FLD; f++)
        if (rd_addr == ADDR_W'(grp_addr(g, f))) rd_data = grp_fld[g][f];
  end

endmodule

// File: rtl/vw_event_irq_chk.sv
module vw_event_irq_chk
  import vw_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_GRP*DATA_W-1:0] vw_in,
  input logic [NUM_GRP*DATA_W-1:0] t0_all,
  input logic [NUM_GRP*DATA_W-1:0] t1_all,
  input logic [NUM_GRP*DATA_W-1:0] t2_all,
  input logic [NUM_GRP*DATA_W-1:0] en_all,
  input logic [NUM_GRP*DATA_W-1:0] st_all,
  input logic                      wr_en,
  input logic                      mrst_evt,
  input logic [DATA_W-1:0]         top_st,
  input logic                      irq
);

  localparam int ALL_W = NUM_GRP * DATA_W;

  logic [ALL_W-1:0] rise_mask, dead_mask;
  assign rise_mask = ~t2_all & ~t1_all & t0_all;
  assign dead_mask = t2_all & (t1_all | t0_all);

  // R7: no status bit appears unless enabled in the clock before
  assert_set_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_all & ~$past(st_all) & ~$past(en_all)) == '0));

  // R8: a status bit only drops after a write
  assert_clear_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((~st_all & $past(st_all)) == '0) || $past(wr_en)));

  // R6: reserved codes stay silent
  assert_reserved_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_all & ~$past(st_all) & $past(dead_mask)) == '0));

  // R2: rising-edge bits only set when the input was high
  assert_rise_needs_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_all & ~$past(st_all) & $past(rise_mask) & ~$past(vw_in)) == '0));

  // R10: a master reset event is always recorded
  assert_mrst_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mrst_evt |=> top_st[MRST_BIT]);

  // R11: no interrupt without a pending top-level bit
  assert_irq_has_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (top_st != '0));

endmodule

bind vw_event_irq vw_event_irq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .vw_in    (vw_in),
  .t0_all   (t0_all),
  .t1_all   (t1_all),
  .t2_all   (t2_all),
  .en_all   (en_all),
  .st_all   (st_all),
  .wr_en    (wr_en),
  .mrst_evt (mrst_evt),
  .top_st   (top_st),
  .irq      (irq)
);

// File: tb/vw_event_irq_test.sv
module vw_event_irq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] vw0 = '0, vw1 = '0;
  logic        mrst_evt = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [3:0] A_TEN = 4'd0, A_TST = 4'd1;
  localparam logic [3:0] G0_T0 = 4'd2, G0_T1 = 4'd3, G0_T2 = 4'd4, G0_EN = 4'd5, G0_ST = 4'd6;
  localparam logic [3:0] G1_T0 = 4'd7, G1_T1 = 4'd8, G1_T2 = 4'd9, G1_EN = 4'd10, G1_ST = 4'd11;

  always #5 clk = ~clk;

  vw_event_irq uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .vw_in    ({vw1, vw0}),
    .mrst_evt (mrst_evt),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .irq      (irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; vw0 = '0; vw1 = '0; mrst_evt = 1'b0; wr_en = 1'b0;
    repeat (2) step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    check(tag, rd_data, exp);
  endtask

  task automatic t_reset();
    do_reset();
    for (int a = 0; a < 14; a++) rd_chk("R1 reset value", 4'(a), 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_rise();
    do_reset();
    wr(G0_T0, 32'h8); wr(G0_EN, 32'h8);
    vw0[3] = 1'b1; step();
    rd_chk("R2 rise sets", G0_ST, 32'h8);
    wr(G0_ST, 32'h8);
    rd_chk("R8 w1c clears", G0_ST, 32'h0);
    vw0[3] = 1'b0; step();
    rd_chk("R2 fall ignored", G0_ST, 32'h0);
  endtask

  task automatic t_fall();
    do_reset();
    wr(G0_EN, 32'h20);
    vw0[5] = 1'b1; step();
    rd_chk("R3 rise ignored", G0_ST, 32'h0);
    vw0[5] = 1'b0; step();
    rd_chk("R3 fall sets", G0_ST, 32'h20);
  endtask

  task automatic t_both();
    do_reset();
    wr(G0_T2, 32'h80); wr(G0_EN, 32'h80);
    vw0[7] = 1'b1; step();
    rd_chk("R4 rise sets", G0_ST, 32'h80);
    wr(G0_ST, 32'h0);
    rd_chk("R8 write 0 keeps", G0_ST, 32'h80);
    vw0[7] = 1'b0; wr(G0_ST, 32'h80);
    rd_chk("R8 trigger beats clear", G0_ST, 32'h80);
    wr(G0_ST, 32'h80);
    rd_chk("R4 cleared", G0_ST, 32'h0);
    vw0[7] = 1'b1; step(); wr(G0_ST, 32'h80);
    vw0[7] = 1'b0; step();
    rd_chk("R4 fall sets", G0_ST, 32'h80);
  endtask

  task automatic t_level();
    do_reset();
    vw0[10] = 1'b1;
    wr(G0_T1, 32'h600); wr(G0_T0, 32'h400); wr(G0_EN, 32'h600);
    rd_chk("R5 idle levels", G0_ST, 32'h0);
    vw0[9] = 1'b1; step();
    rd_chk("R5 level high sets", G0_ST, 32'h200);
    wr(G0_ST, 32'h200);
    rd_chk("R5 clear under level", G0_ST, 32'h200);
    vw0[9] = 1'b0; step(); wr(G0_ST, 32'h200);
    rd_chk("R5 clear after level", G0_ST, 32'h0);
    vw0[10] = 1'b0; step();
    rd_chk("R5 level low sets", G0_ST, 32'h400);
  endtask

  task automatic t_reserved();
    do_reset();
    wr(A_TEN, 32'hFFFF_FFFF);
    wr(G0_T2, 32'h7); wr(G0_T1, 32'h6); wr(G0_T0, 32'h5); wr(G0_EN, 32'h7);
    vw0[2:0] = 3'b111; step();
    vw0[2:0] = 3'b000; step();
    rd_chk("R6 reserved codes", G0_ST, 32'h0);
    check("R6 no irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_enable();
    do_reset();
    wr(G0_T0, 32'h10);
    vw0[4] = 1'b1; step();
    rd_chk("R7 disabled edge", G0_ST, 32'h0);
    wr(G0_EN, 32'h10); step();
    rd_chk("R7 no replay", G0_ST, 32'h0);
    vw0[4] = 1'b0; step();
    vw0[4] = 1'b1; step();
    rd_chk("R7 enabled edge", G0_ST, 32'h10);
  endtask

  task automatic t_summary();
    do_reset();
    wr(A_TEN, 32'h100);
    wr(G1_T0, 32'h0010_0000); wr(G1_EN, 32'h0010_0000);
    vw1[20] = 1'b1; step();
    rd_chk("R9 group1 summary", A_TST, 32'h0040_0000);
    check("R11 masked irq", {31'b0, irq}, 32'h0);
    wr(A_TEN, 32'hFFFF_FFFF);
    check("R11 irq high", {31'b0, irq}, 32'h1);
    wr(A_TST, 32'h0040_0000);
    rd_chk("R9 summary not writable", A_TST, 32'h0040_0000);
    wr(G1_EN, 32'h0);
    rd_chk("R9 summary uses enable", A_TST, 32'h0);
    rd_chk("R9 status kept", G1_ST, 32'h0010_0000);
    check("R11 irq low", {31'b0, irq}, 32'h0);
    wr(G0_T0, 32'h8); wr(G0_EN, 32'h8);
    vw0[3] = 1'b1; step();
    rd_chk("R9 group0 summary", A_TST, 32'h0000_0100);
    check("R11 irq group0", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_mrst();
    do_reset();
    mrst_evt = 1'b1; step(); mrst_evt = 1'b0;
    rd_chk("R10 sticky set", A_TST, 32'h8000_0000);
    check("R11 irq off", {31'b0, irq}, 32'h0);
    wr(A_TEN, 32'h8000_0000);
    check("R11 irq on", {31'b0, irq}, 32'h1);
    wr(A_TST, 32'h0000_0100);
    rd_chk("R10 other bit write", A_TST, 32'h8000_0000);
    mrst_evt = 1'b1; wr(A_TST, 32'h8000_0000); mrst_evt = 1'b0;
    rd_chk("R10 event beats clear", A_TST, 32'h8000_0000);
    wr(A_TST, 32'h8000_0000);
    rd_chk("R10 w1c", A_TST, 32'h0);
    check("R11 irq cleared", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_map();
    do_reset();
    wr(A_TEN, 32'hDEAD_BEEF);
    wr(G1_T0, 32'hA5A5_0001); wr(G1_T1, 32'h1234_5678);
    wr(G1_T2, 32'h0F0F_0F0F); wr(G1_EN, 32'hFFFF_0000);
    wr(G0_T1, 32'h0000_C3C3);
    rd_chk("R12 top enable", A_TEN, 32'hDEAD_BEEF);
    rd_chk("R12 g1 T0", G1_T0, 32'hA5A5_0001);
    rd_chk("R12 g1 T1", G1_T1, 32'h1234_5678);
    rd_chk("R12 g1 T2", G1_T2, 32'h0F0F_0F0F);
    rd_chk("R12 g1 EN", G1_EN, 32'hFFFF_0000);
    rd_chk("R12 g0 T1", G0_T1, 32'h0000_C3C3);
    rd_chk("R12 g0 T0 untouched", G0_T0, 32'h0);
    rd_chk("R12 unmapped", 4'd15, 32'h0);
  endtask

  initial begin
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_reserved();
    t_enable();
    t_summary();
    t_mrst();
    t_map();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule